// File: doc/BRIEF.md
# SDRAM Page and Timing Guard

This block works next to an SDRAM command sequencer and tells it when commands may go out. It watches the command strobes the sequencer issues and applies three timing rules. First, it keeps a countdown for the open page and asks for a precharge once the page has been idle too long. Second, it keeps activate commands blocked for a set number of cycles after a refresh. Third, it raises a strobe when the first data beat of each read is due.

The idle interval of the page has ten bits, built from three configuration fields. Every read or write to the open page loads the full interval into the counter again. The refresh recovery time and the read latency each come from a 4-bit code. A refresh recovery code of zero means the longest recovery time. A read latency code outside its legal range blocks the strobe for that read and sets an error flag that stays set.

Top module: `sdram_timing_guard`

## Requirements
- R1: While reset is held and directly after it ends, `pre_req`, `first_beat` and `cfg_err` are 0 and `act_ok` is 1.
- R2: The page interval N is `{cfg_page_hi, cfg_page_mid, cfg_page_lo}`, with `cfg_page_hi` as the most significant bits. Take edge E as the clock edge that samples `cmd_act`. With no later access, `pre_req` is 0 after edges E through E+N and is 1 after edge E+N+1.
- R3: A `cmd_rd` or `cmd_wr` sampled at edge R, while a page is open and no precharge request is pending, loads N again. `pre_req` then rises after edge R+N+1 and not before.
- R4: Once `pre_req` is high, it stays high until a `pre_done` or `cmd_ref` is sampled. After that edge it is 0, and it stays 0 until a new `cmd_act` is sampled.
- R5: Take L as `cfg_ref_rec`, with code 0 meaning L = 16. When `cmd_ref` is sampled at edge E, `act_ok` is 0 after every edge from E through E+L.
- R6: `act_ok` is 1 again after edge E+L+1, provided no further refresh arrives.
- R7: Take `cmd_rd` sampled at edge E while `cfg_rd_lat` is a code from 1 to 6. `first_beat` is then 1 for exactly the cycle after edge E+`cfg_rd_lat`.
- R8: Reads sampled on consecutive edges, all with the same valid latency, each give their own one-cycle `first_beat` pulse, on consecutive cycles.
- R9: A `cmd_rd` sampled while `cfg_rd_lat` is 0 or 7 to 15 gives no `first_beat` pulse. It sets `cfg_err` after that edge, and `cfg_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_act | input | 1 | Activate command issued this cycle |
| cmd_rd | input | 1 | Read command issued this cycle |
| cmd_wr | input | 1 | Write command issued this cycle |
| cmd_ref | input | 1 | Refresh command issued this cycle |
| pre_done | input | 1 | Precharge of the open page has been issued |
| cfg_page_hi | input | 2 | Most significant bits of the page interval |
| cfg_page_mid | input | 4 | Middle bits of the page interval |
| cfg_page_lo | input | 4 | Least significant bits of the page interval |
| cfg_ref_rec | input | 4 | Refresh recovery code (0 means 16) |
| cfg_rd_lat | input | 4 | Read latency code (1 to 6 are valid) |
| pre_req | output | 1 | Request to precharge the open page |
| act_ok | output | 1 | An activate may be issued |
| first_beat | output | 1 | First read data beat is due this cycle |
| cfg_err | output | 1 | Sticky flag: a read was issued with an illegal latency code |

## Verification
The assertions assume that the configuration fields stay steady while a countdown or a read that depends on them is in progress. They also assume that reads in flight all share one latency, so that two reads never fall due in the same slot. The stimulus changes the configuration only during idle gaps, after every pending pulse has come out. Bursts of reads are always issued with a single latency code. Activates are sent only to start a fresh page, never while a precharge request is pending.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    // Range of legal read latency codes
    localparam int unsigned LAT_CODE_MIN = 1;

    function automatic logic lat_code_legal(input int unsigned code, input int unsigned max_code);
        return (code >= LAT_CODE_MIN) && (code <= max_code);
    endfunction

endpackage

// File: rtl/page_timer.sv
module page_timer #(
    parameter int unsigned HI_W  = 2,
    parameter int unsigned MID_W = 4,
    parameter int unsigned LO_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_act,
    input  logic                  cmd_access,
    input  logic                  close_evt,
    input  logic [HI_W-1:0]       fld_hi,
    input  logic [MID_W-1:0]      fld_mid,
    input  logic [LO_W-1:0]       fld_lo,
    output logic                  close_req
);
    localparam int unsigned SPAN_W = HI_W + MID_W + LO_W;

    typedef struct packed {
        logic              open;
        logic              req;
        logic [SPAN_W-1:0] cnt;
    } pg_state_t;

    pg_state_t         pg_d, pg_q;
    logic [SPAN_W-1:0] span;

    assign span = {fld_hi, fld_mid, fld_lo};

    always_comb begin
        pg_d = pg_q;
        if (close_evt) begin
            pg_d = '0;
        end else if (cmd_act) begin
            pg_d.open = 1'b1;
            pg_d.req  = 1'b0;
            pg_d.cnt  = span;
        end else if (pg_q.open && !pg_q.req) begin
            if (cmd_access) begin
                pg_d.cnt = span;
            end else if (pg_q.cnt == '0) begin
                pg_d.req = 1'b1;
            end else begin
                pg_d.cnt = pg_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign close_req = pg_q.req;

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && !close_evt) |=> close_req);
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        close_evt |=> !close_req);
    assert_hit_defers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q.open && !pg_q.req && cmd_access && !close_evt && !cmd_act) |=> !close_req);
    assert_req_needs_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_q.open && !cmd_act) |=> !close_req);

endmodule

// File: rtl/refresh_guard.sv
module refresh_guard #(
    parameter int unsigned REC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ref,
    input  logic [REC_W-1:0] rec_code,
    output logic             act_ok
);
    localparam int unsigned CNT_W = REC_W + 1;

    typedef struct packed {
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } rg_state_t;

    rg_state_t        rg_d, rg_q;
    logic [CNT_W-1:0] load_val;

    // A zero code selects the longest recovery time
    assign load_val = (rec_code == '0) ? {1'b1, {REC_W{1'b0}}} : {1'b0, rec_code};

    always_comb begin
        rg_d = rg_q;
        if (cmd_ref) begin
            rg_d.cnt = load_val;
        end else if (rg_q.cnt != '0) begin
            rg_d.cnt = rg_q.cnt - 1'b1;
        end
        rg_d.ok = !cmd_ref && (rg_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '{ok: 1'b1, cnt: '0};
        else        rg_q <= rg_d;
    end

    assign act_ok = rg_q.ok;

    assert_ref_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |=> !act_ok);
    assert_count_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.cnt != '0) |=> !act_ok);
    assert_recovers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.cnt == '0 && !cmd_ref) |=> act_ok);

endmodule

// File: rtl/read_beat_tracker.sv
module read_beat_tracker
    import sdram_guard_pkg::*;
#(
    parameter int unsigned LAT_W   = 4,
    parameter int unsigned LAT_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic [LAT_W-1:0] lat_code,
    output logic             beat,
    output logic             bad_cfg
);
    typedef struct packed {
        logic               err;
        logic               fb;
        logic [LAT_MAX-1:0] pipe;
    } rt_state_t;

    rt_state_t rt_d, rt_q;
    logic      lat_ok;

    assign lat_ok = lat_code_legal(int'(lat_code), LAT_MAX);

    always_comb begin
        rt_d      = rt_q;
        rt_d.fb   = rt_q.pipe[0];
        rt_d.pipe = rt_q.pipe >> 1;
        if (cmd_rd) begin
            if (lat_ok) begin
                for (int i = 0; i < int'(LAT_MAX); i++) begin
                    if (int'(lat_code) == i + 1) rt_d.pipe[i] = 1'b1;
                end
            end else begin
                rt_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign beat    = rt_q.fb;
    assign bad_cfg = rt_q.err;

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg |=> bad_cfg);
    assert_bad_read_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !lat_ok) |=> bad_cfg);
    assert_beat_follows_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.pipe[0] |=> beat);
    assert_no_stray_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_q.pipe[0] |=> !beat);

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard #(
    parameter int unsigned HI_W    = 2,
    parameter int unsigned MID_W   = 4,
    parameter int unsigned LO_W    = 4,
    parameter int unsigned REC_W   = 4,
    parameter int unsigned LAT_W   = 4,
    parameter int unsigned LAT_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_act,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_ref,
    input  logic             pre_done,
    input  logic [HI_W-1:0]  cfg_page_hi,
    input  logic [MID_W-1:0] cfg_page_mid,
    input  logic [LO_W-1:0]  cfg_page_lo,
    input  logic [REC_W-1:0] cfg_ref_rec,
    input  logic [LAT_W-1:0] cfg_rd_lat,
    output logic             pre_req,
    output logic             act_ok,
    output logic             first_beat,
    output logic             cfg_err
);
    logic page_access;
    logic page_close;

    assign page_access = cmd_rd | cmd_wr;
    assign page_close  = pre_done | cmd_ref;

    page_timer #(
        .HI_W (HI_W),
        .MID_W(MID_W),
        .LO_W (LO_W)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_act   (cmd_act),
        .cmd_access(page_access),
        .close_evt (page_close),
        .fld_hi    (cfg_page_hi),
        .fld_mid   (cfg_page_mid),
        .fld_lo    (cfg_page_lo),
        .close_req (pre_req)
    );

    refresh_guard #(
        .REC_W(REC_W)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_ref (cmd_ref),
        .rec_code(cfg_ref_rec),
        .act_ok  (act_ok)
    );

    read_beat_tracker #(
        .LAT_W  (LAT_W),
        .LAT_MAX(LAT_MAX)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_rd  (cmd_rd),
        .lat_code(cfg_rd_lat),
        .beat    (first_beat),
        .bad_cfg (cfg_err)
    );

endmodule

// File: tb/sim_sdram_timing_guard.sv
`timescale 1ns/1ps
module sim_sdram_timing_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_act, cmd_rd, cmd_wr, cmd_ref, pre_done;
    logic [1:0] cfg_page_hi;
    logic [3:0] cfg_page_mid, cfg_page_lo, cfg_ref_rec, cfg_rd_lat;
    logic       pre_req, act_ok, first_beat, cfg_err;

    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    int unsigned expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_timing_guard u0 (
        .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_ref(cmd_ref), .pre_done(pre_done), .cfg_page_hi(cfg_page_hi),
        .cfg_page_mid(cfg_page_mid), .cfg_page_lo(cfg_page_lo), .cfg_ref_rec(cfg_ref_rec),
        .cfg_rd_lat(cfg_rd_lat), .pre_req(pre_req), .act_ok(act_ok),
        .first_beat(first_beat), .cfg_err(cfg_err)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Monitor: compares first_beat against the scoreboard queue
    initial forever begin
        @(posedge clk);
        #5;
        while (expq.size() > 0 && expq[0] < cyc) begin
            check("R7", "missed first beat", 0, 1);
            void'(expq.pop_front());
        end
        if (first_beat) begin
            if (expq.size() > 0 && expq[0] == cyc) begin
                check("R7", "first beat on time", 1, 1);
                void'(expq.pop_front());
            end else begin
                check("R9", "unexpected first beat", 1, 0);
            end
        end
    end

    // Drivers: entered and left at a falling edge
    task automatic pulse_act();
        cmd_act = 1'b1; @(negedge clk); cmd_act = 1'b0;
    endtask
    task automatic pulse_wr();
        cmd_wr = 1'b1; @(negedge clk); cmd_wr = 1'b0;
    endtask
    task automatic pulse_ref();
        cmd_ref = 1'b1; @(negedge clk); cmd_ref = 1'b0;
    endtask
    task automatic pulse_pre_done();
        pre_done = 1'b1; @(negedge clk); pre_done = 1'b0;
    endtask
    task automatic rd_burst(input int n);
        for (int i = 0; i < n; i++) begin
            cmd_rd = 1'b1;
            if (cfg_rd_lat >= 1 && cfg_rd_lat <= 6) expq.push_back(cyc + 1 + cfg_rd_lat);
            @(negedge clk);
        end
        cmd_rd = 1'b0;
    endtask

    task automatic page_window(input string rq, input int n);
        repeat (n) @(negedge clk);
        check(rq, "pre_req just before expiry", int'(pre_req), 0);
        @(negedge clk);
        check(rq, "pre_req at expiry", int'(pre_req), 1);
    endtask

    task automatic ref_window(input string rq, input int len);
        for (int k = 0; k <= len + 1; k++) begin
            if (k > 0) @(negedge clk);
            check(rq, $sformatf("act_ok %0d cycles after refresh", k), int'(act_ok),
                  (k <= len) ? 0 : 1);
        end
    endtask

    initial begin
        #(200000 * 20);
        check("R1", "watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {cmd_act, cmd_rd, cmd_wr, cmd_ref, pre_done} = '0;
        cfg_page_hi = '0; cfg_page_mid = '0; cfg_page_lo = '0;
        cfg_ref_rec = '0; cfg_rd_lat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        check("R1", "pre_req after reset", int'(pre_req), 0);
        check("R1", "act_ok after reset", int'(act_ok), 1);
        check("R1", "first_beat after reset", int'(first_beat), 0);
        check("R1", "cfg_err after reset", int'(cfg_err), 0);

        // R2: interval 0_0001_0011 = 19
        cfg_page_mid = 4'd1; cfg_page_lo = 4'd3;
        pulse_act();
        page_window("R2", 19);
        // R4: request held until precharge done
        repeat (5) @(negedge clk);
        check("R4", "pre_req held", int'(pre_req), 1);
        pulse_pre_done();
        check("R4", "pre_req cleared by pre_done", int'(pre_req), 0);
        repeat (40) @(negedge clk);
        check("R4", "no request without open page", int'(pre_req), 0);

        // R2: high field in use, 10_0000_0101 = 517
        cfg_page_hi = 2'd2; cfg_page_mid = 4'd0; cfg_page_lo = 4'd5;
        pulse_act();
        page_window("R2", 517);
        // R4 and R5: refresh clears request; code 0 gives 16 cycles
        cfg_ref_rec = 4'd0;
        pulse_ref();
        check("R4", "pre_req cleared by refresh", int'(pre_req), 0);
        ref_window("R5", 16);
        check("R6", "act_ok back after code 0", int'(act_ok), 1);

        // R5/R6: code 5
        cfg_ref_rec = 4'd5;
        repeat (3) @(negedge clk);
        pulse_ref();
        ref_window("R6", 5);

        // R3: a write reloads the page timer
        cfg_page_hi = 2'd0; cfg_page_mid = 4'd1; cfg_page_lo = 4'd3;
        pulse_act();
        repeat (10) @(negedge clk);
        pulse_wr();
        page_window("R3", 19);
        pulse_pre_done();

        // R3: a read reloads the page timer as well (latency 3)
        cfg_rd_lat = 4'd3;
        pulse_act();
        repeat (12) @(negedge clk);
        rd_burst(1);
        page_window("R3", 19);
        pulse_pre_done();
        repeat (10) @(negedge clk);

        // R7: each legal latency
        for (int l = 1; l <= 6; l++) begin
            cfg_rd_lat = 4'(l);
            rd_burst(1);
            repeat (10) @(negedge clk);
        end

        // R8: back-to-back reads
        cfg_rd_lat = 4'd4;
        rd_burst(3);
        repeat (12) @(negedge clk);
        cfg_rd_lat = 4'd1;
        rd_burst(4);
        repeat (10) @(negedge clk);
        check("R8", "all burst beats seen", expq.size(), 0);

        // R9: reserved codes
        check("R9", "cfg_err before bad read", int'(cfg_err), 0);
        cfg_rd_lat = 4'd7;
        rd_burst(1);
        check("R9", "cfg_err after code 7", int'(cfg_err), 1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R9", "no beat for reserved code", int'(first_beat), 0);
        end
        cfg_rd_lat = 4'd0;
        rd_burst(1);
        repeat (10) @(negedge clk);
        check("R9", "cfg_err after code 0", int'(cfg_err), 1);
        cfg_rd_lat = 4'd2;
        rd_burst(1);
        repeat (8) @(negedge clk);
        check("R9", "cfg_err sticky after valid read", int'(cfg_err), 1);
        check("R7", "queue drained", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule